// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Control Register Bank

This block is the register bank on the control and interrupt side of a real-time clock. It is reached through a simple word-wide port: one access per cycle, a write-enable, a byte address and four byte lanes. It keeps two interrupt groups. The timekeeping group has a seconds flag and an alarm flag. The bus-fault group has a single flag, which is raised when an access cannot be decoded. Each group drives its own level interrupt line.

Pulses from the counting datapath raise the timekeeping flags. Software clears a flag by writing a one to its bit. Software cannot write a mask directly. It changes a mask through a pair of strobe registers: one unmasks the selected bits and the other masks them. The bank also holds the set-time word, the alarm word and a control word, and it presents the live time and sub-second tick, which are read-only.

Top module: `rtc_irq_bank`

## Requirements
- R1: After reset, every flag reads 0, the timekeeping mask (0x24) reads 0x3, the bus-fault mask (0x34) reads 0x1, the control word (0x40) reads 0x01000000, and both interrupt lines are low.
- R2: In the timekeeping status word (0x20), bit 0 is the seconds flag and bit 1 is the alarm flag. A `seconds_evt` pulse sets bit 0 and an `alarm_evt` pulse sets bit 1. Writing a 1 to a bit clears it. If a set pulse and a clearing write reach the same bit in the same cycle, the bit stays set.
- R3: Writes to the mask words 0x24 and 0x34 leave both masks unchanged.
- R4: A write to 0x28 or 0x38 clears every mask bit whose data bit is 1. A write to 0x2C or 0x3C sets every mask bit whose data bit is 1. These four strobe words read as 0.
- R5: `irq_time` is high exactly when some timekeeping flag is set while its mask bit is 0. `irq_fault` follows the same rule for the bus-fault group. Each line takes its new level at the same clock edge as the flag or mask change that causes it.
- R6: An access is rejected when its offset is unmapped, when address bits 1:0 are not zero, or when not all four byte enables are set. A rejected access sets bit 0 of the bus-fault status word (0x30, write 1 to clear), changes no stored value, and returns read data 0.
- R7: `bus_slverr` pulses high for the one cycle after a rejected access, but only while control bit 0 is set.
- R8: In the control word, only bit 31 (`batt_off`), bits 27:24 (`osc_trim`) and bit 0 (bus-error reply enable) can be written. All other bits read as 0.
- R9: The set-time word (0x00) and the alarm word (0x18) can be read and written, and each drives its own output port.
- R10: Offset 0x10 returns `cur_time` and offset 0x14 returns `cur_tick` with bits 31:16 at zero. Writes to either offset are ignored.
- R11: Read data is registered. It appears after the clock edge that accepts the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_slverr | output | 1 | Error reply for a rejected access |
| seconds_evt | input | 1 | One-cycle seconds pulse |
| alarm_evt | input | 1 | One-cycle alarm-match pulse |
| cur_time | input | 32 | Live seconds count |
| cur_tick | input | 16 | Live sub-second tick |
| set_time_o | output | 32 | Stored set-time word |
| alarm_o | output | 32 | Stored alarm word |
| osc_trim | output | 4 | Oscillator control field |
| batt_off | output | 1 | Battery disable bit |
| irq_time | output | 1 | Timekeeping interrupt level |
| irq_fault | output | 1 | Bus-fault interrupt level |

## Verification
All results of an access or an event pulse are due one edge after it is presented: read data, the error reply, flag and mask updates, and both interrupt levels. The interrupt registers load from the next-state values, so they add no extra cycle. The bench drives every stimulus on a falling edge for exactly one cycle and samples at the following falling edge, which is half a period after the edge that produces the result. A value that depends on an earlier change is read only after that change has settled.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DW = 32;
  localparam int TIME_GRP_W = 2;
  localparam int FAULT_GRP_W = 1;
  localparam int TICK_W = 16;

  localparam logic [7:0] OFS_SET_TIME  = 8'h00;
  localparam logic [7:0] OFS_CUR_TIME  = 8'h10;
  localparam logic [7:0] OFS_CUR_TICK  = 8'h14;
  localparam logic [7:0] OFS_ALARM     = 8'h18;
  localparam logic [7:0] OFS_T_STAT    = 8'h20;
  localparam logic [7:0] OFS_T_MASK    = 8'h24;
  localparam logic [7:0] OFS_T_UNMASK  = 8'h28;
  localparam logic [7:0] OFS_T_MASKSET = 8'h2C;
  localparam logic [7:0] OFS_F_STAT    = 8'h30;
  localparam logic [7:0] OFS_F_MASK    = 8'h34;
  localparam logic [7:0] OFS_F_UNMASK  = 8'h38;
  localparam logic [7:0] OFS_F_MASKSET = 8'h3C;
  localparam logic [7:0] OFS_CTRL      = 8'h40;

  localparam logic [DW-1:0] CTRL_RESET = 32'h0100_0000;
  localparam logic [DW-1:0] CTRL_WMASK = 32'h8F00_0001;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SET_TIME, SEL_CUR_TIME, SEL_CUR_TICK, SEL_ALARM,
    SEL_T_STAT, SEL_T_MASK, SEL_T_UNMASK, SEL_T_MASKSET,
    SEL_F_STAT, SEL_F_MASK, SEL_F_UNMASK, SEL_F_MASKSET, SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/rtc_reg_decode.sv
module rtc_reg_decode
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              acc_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_be,
  output reg_sel_e          sel,
  output logic              reject
);
  always_comb begin
    case (acc_addr)
      ADDR_W'(OFS_SET_TIME):  sel = SEL_SET_TIME;
      ADDR_W'(OFS_CUR_TIME):  sel = SEL_CUR_TIME;
      ADDR_W'(OFS_CUR_TICK):  sel = SEL_CUR_TICK;
      ADDR_W'(OFS_ALARM):     sel = SEL_ALARM;
      ADDR_W'(OFS_T_STAT):    sel = SEL_T_STAT;
      ADDR_W'(OFS_T_MASK):    sel = SEL_T_MASK;
      ADDR_W'(OFS_T_UNMASK):  sel = SEL_T_UNMASK;
      ADDR_W'(OFS_T_MASKSET): sel = SEL_T_MASKSET;
      ADDR_W'(OFS_F_STAT):    sel = SEL_F_STAT;
      ADDR_W'(OFS_F_MASK):    sel = SEL_F_MASK;
      ADDR_W'(OFS_F_UNMASK):  sel = SEL_F_UNMASK;
      ADDR_W'(OFS_F_MASKSET): sel = SEL_F_MASKSET;
      ADDR_W'(OFS_CTRL):      sel = SEL_CTRL;
      default:                sel = SEL_NONE;
    endcase
  end

  // misaligned addresses never hit a table entry, so the SEL_NONE check covers them
  assign reject = acc_en && ((acc_be != 4'hF) || (sel == SEL_NONE));
endmodule

// File: rtl/rtc_irq_group.sv
module rtc_irq_group #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] unmask_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] status_q, mask_q, status_d, mask_d;
  logic         irq_q;

  // a set pulse takes priority over a clearing write
  assign status_d = (status_q & ~clr_i) | set_i;
  assign mask_d   = (mask_q & ~unmask_i) | mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_q    <= |(status_d & ~mask_d);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i))); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~set_i)) |=> ((status_o & $past(clr_i & ~set_i)) == '0)); // R2
  AST_UNMASK: assert property (@(posedge clk) disable iff (rst)
    (|(unmask_i & ~mask_i)) |=> ((mask_o & $past(unmask_i & ~mask_i)) == '0)); // R4
  AST_MASKSET: assert property (@(posedge clk) disable iff (rst)
    (|mask_i) |=> ((mask_o & $past(mask_i)) == $past(mask_i))); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((unmask_i == '0) && (mask_i == '0)) |=> $stable(mask_o)); // R3
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(status_o & ~mask_o))); // R5
endmodule

// File: rtl/rtc_irq_bank.sv
module rtc_irq_bank
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_slverr,
  input  logic              seconds_evt,
  input  logic              alarm_evt,
  input  logic [DW-1:0]     cur_time,
  input  logic [TICK_W-1:0] cur_tick,
  output logic [DW-1:0]     set_time_o,
  output logic [DW-1:0]     alarm_o,
  output logic [3:0]        osc_trim,
  output logic              batt_off,
  output logic              irq_time,
  output logic              irq_fault
);
  reg_sel_e sel;
  logic     reject, wr, rd;

  rtc_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .acc_en(bus_en), .acc_addr(bus_addr), .acc_be(bus_be),
    .sel(sel), .reject(reject)
  );

  assign wr = bus_en && bus_we && !reject;
  assign rd = bus_en && !bus_we;

  logic [TIME_GRP_W-1:0]  t_status, t_mask;
  logic [FAULT_GRP_W-1:0] f_status, f_mask;

  rtc_irq_group #(.W(TIME_GRP_W)) u_time_grp (
    .clk(clk), .rst(rst),
    .set_i({alarm_evt, seconds_evt}),
    .clr_i   ((wr && sel == SEL_T_STAT)    ? bus_wdata[TIME_GRP_W-1:0] : '0),
    .unmask_i((wr && sel == SEL_T_UNMASK)  ? bus_wdata[TIME_GRP_W-1:0] : '0),
    .mask_i  ((wr && sel == SEL_T_MASKSET) ? bus_wdata[TIME_GRP_W-1:0] : '0),
    .status_o(t_status), .mask_o(t_mask), .irq_o(irq_time)
  );

  rtc_irq_group #(.W(FAULT_GRP_W)) u_fault_grp (
    .clk(clk), .rst(rst),
    .set_i(reject),
    .clr_i   ((wr && sel == SEL_F_STAT)    ? bus_wdata[FAULT_GRP_W-1:0] : '0),
    .unmask_i((wr && sel == SEL_F_UNMASK)  ? bus_wdata[FAULT_GRP_W-1:0] : '0),
    .mask_i  ((wr && sel == SEL_F_MASKSET) ? bus_wdata[FAULT_GRP_W-1:0] : '0),
    .status_o(f_status), .mask_o(f_mask), .irq_o(irq_fault)
  );

  logic [DW-1:0] set_time_q, alarm_q, ctrl_q, rd_mux, rdata_q;
  logic          slverr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      set_time_q <= '0;
      alarm_q    <= '0;
      ctrl_q     <= CTRL_RESET;
    end else if (wr) begin
      case (sel)
        SEL_SET_TIME: set_time_q <= bus_wdata;
        SEL_ALARM:    alarm_q    <= bus_wdata;
        SEL_CTRL:     ctrl_q     <= bus_wdata & CTRL_WMASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_SET_TIME: rd_mux = set_time_q;
      SEL_CUR_TIME: rd_mux = cur_time;
      SEL_CUR_TICK: rd_mux = DW'(cur_tick);
      SEL_ALARM:    rd_mux = alarm_q;
      SEL_T_STAT:   rd_mux = DW'(t_status);
      SEL_T_MASK:   rd_mux = DW'(t_mask);
      SEL_F_STAT:   rd_mux = DW'(f_status);
      SEL_F_MASK:   rd_mux = DW'(f_mask);
      SEL_CTRL:     rd_mux = ctrl_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      slverr_q <= 1'b0;
    end else begin
      if (rd) rdata_q <= reject ? '0 : rd_mux;
      slverr_q <= reject && ctrl_q[0];
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_slverr = slverr_q;
  assign set_time_o = set_time_q;
  assign alarm_o    = alarm_q;
  assign osc_trim   = ctrl_q[27:24];
  assign batt_off   = ctrl_q[31];

  AST_SLVERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    bus_slverr |-> $past(reject)); // R7
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    reject |=> f_status[0]); // R6
  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~CTRL_WMASK) == '0); // R8
  AST_REJECT_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reject && !bus_we) |=> (bus_rdata == '0)); // R6
endmodule

// File: tb/test_rtc_irq_bank.sv
module test_rtc_irq_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 0, bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_slverr;
  logic        seconds_evt = 0, alarm_evt = 0;
  logic [31:0] cur_time = '0;
  logic [15:0] cur_tick = '0;
  logic [31:0] set_time_o, alarm_o;
  logic [3:0]  osc_trim;
  logic        batt_off, irq_time, irq_fault;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rtc_irq_bank i_rtc_irq_bank (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_slverr(bus_slverr), .seconds_evt(seconds_evt), .alarm_evt(alarm_evt),
    .cur_time(cur_time), .cur_tick(cur_tick), .set_time_o(set_time_o),
    .alarm_o(alarm_o), .osc_trim(osc_trim), .batt_off(batt_off),
    .irq_time(irq_time), .irq_fault(irq_fault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle access; results are sampled at the following falling edge
  task automatic acc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] be);
    @(negedge clk);
    bus_en = 1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_be = 4'hF;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    acc(1'b1, a, d, 4'hF);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    acc(1'b0, a, 32'h0, 4'hF);
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq_time", {31'b0, irq_time}, 0);
    chk("R1 irq_fault", {31'b0, irq_fault}, 0);
    rd_chk("R1 time mask", 8'h24, 32'h3);
    rd_chk("R1 fault mask", 8'h34, 32'h1);
    rd_chk("R1 ctrl", 8'h40, 32'h0100_0000);
    rd_chk("R1 time status", 8'h20, 32'h0);
    rd_chk("R1 fault status", 8'h30, 32'h0);
  endtask

  task automatic t_time_group;
    @(negedge clk); seconds_evt = 1;
    @(negedge clk); seconds_evt = 0;
    chk("R5 masked seconds no irq", {31'b0, irq_time}, 0);
    rd_chk("R2 seconds flag bit0", 8'h20, 32'h1);
    wr(8'h24, 32'h0);
    rd_chk("R3 time mask write ignored", 8'h24, 32'h3);
    wr(8'h28, 32'h1);
    chk("R5 irq on unmask same edge", {31'b0, irq_time}, 1);
    rd_chk("R4 unmask clears bit0", 8'h24, 32'h2);
    rd_chk("R4 unmask reads zero", 8'h28, 32'h0);
    wr(8'h20, 32'h1);
    chk("R5 irq drops on clear", {31'b0, irq_time}, 0);
    rd_chk("R2 w1c seconds", 8'h20, 32'h0);
    // set and clear collide: set wins
    @(negedge clk);
    seconds_evt = 1; bus_en = 1; bus_we = 1; bus_addr = 8'h20; bus_wdata = 32'h1;
    @(negedge clk);
    seconds_evt = 0; bus_en = 0; bus_we = 0;
    chk("R2 set wins irq", {31'b0, irq_time}, 1);
    rd_chk("R2 set wins flag", 8'h20, 32'h1);
    @(negedge clk); alarm_evt = 1;
    @(negedge clk); alarm_evt = 0;
    rd_chk("R2 alarm flag bit1", 8'h20, 32'h3);
    wr(8'h2C, 32'h1);
    chk("R5 only masked alarm pending", {31'b0, irq_time}, 0);
    wr(8'h28, 32'h2);
    chk("R5 alarm unmasked", {31'b0, irq_time}, 1);
    wr(8'h2C, 32'h3);
    chk("R5 all masked", {31'b0, irq_time}, 0);
    rd_chk("R4 maskset sets bits", 8'h24, 32'h3);
    rd_chk("R4 maskset reads zero", 8'h2C, 32'h0);
    wr(8'h20, 32'h3);
    rd_chk("R2 w1c both", 8'h20, 32'h0);
  endtask

  task automatic t_storage;
    wr(8'h00, 32'hA5A5_1234);
    rd_chk("R9 set time readback", 8'h00, 32'hA5A5_1234);
    chk("R9 set time port", set_time_o, 32'hA5A5_1234);
    wr(8'h18, 32'h0BAD_F00D);
    rd_chk("R9 alarm readback", 8'h18, 32'h0BAD_F00D);
    chk("R9 alarm port", alarm_o, 32'h0BAD_F00D);
    chk("R11 rdata holds after write", bus_rdata, 32'h0BAD_F00D);
    cur_time = 32'hDEAD_BEEF; cur_tick = 16'h4321;
    wr(8'h10, 32'h0);
    rd_chk("R10 cur time", 8'h10, 32'hDEAD_BEEF);
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk("R10 cur tick", 8'h14, 32'h0000_4321);
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R8 ctrl writable bits", 8'h40, 32'h8F00_0001);
    chk("R8 osc_trim", {28'b0, osc_trim}, 32'hF);
    chk("R8 batt_off", {31'b0, batt_off}, 1);
  endtask

  task automatic t_fault;
    // ctrl bit0 set from t_storage
    acc(1'b0, 8'h44, 32'h0, 4'hF);
    chk("R7 slverr on unmapped", {31'b0, bus_slverr}, 1);
    chk("R6 unmapped reads zero", bus_rdata, 32'h0);
    chk("R5 fault masked", {31'b0, irq_fault}, 0);
    rd_chk("R6 fault flag set", 8'h30, 32'h1);
    chk("R7 slverr one cycle", {31'b0, bus_slverr}, 0);
    wr(8'h38, 32'h1);
    chk("R5 fault irq unmasked", {31'b0, irq_fault}, 1);
    wr(8'h30, 32'h1);
    chk("R5 fault irq cleared", {31'b0, irq_fault}, 0);
    wr(8'h34, 32'h1);
    rd_chk("R3 fault mask write ignored", 8'h34, 32'h0);
    acc(1'b1, 8'h00, 32'h0, 4'h3);
    chk("R6 partial write flags", {31'b0, irq_fault}, 1);
    chk("R6 partial write no effect", set_time_o, 32'hA5A5_1234);
    wr(8'h30, 32'h1);
    acc(1'b1, 8'h02, 32'h0, 4'hF);
    chk("R6 misaligned flags", {31'b0, irq_fault}, 1);
    rd_chk("R6 misaligned no effect", 8'h00, 32'hA5A5_1234);
    wr(8'h30, 32'h1);
    wr(8'h40, 32'h0);
    acc(1'b1, 8'h4C, 32'h0, 4'hF);
    chk("R7 no slverr when disabled", {31'b0, bus_slverr}, 0);
    chk("R6 flag without slverr", {31'b0, irq_fault}, 1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_time_group();
    t_storage();
    t_fault();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule